// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes an incoming Ethernet frame as a byte stream and stores it in a circular receive area of a local buffer RAM made of 16-bit words. Every stored frame starts with a four-word header. The frame data follows the header, two bytes per word. The area is bounded by two host-set page numbers, each naming a 256-byte page. The host also writes a stop address, which marks the last location the block may use. The block therefore never overwrites frames that the host has not yet read.

A frame is committed in a fixed order. The data words are written first. The header is then filled from its highest word down. The done event goes into the first header word last of all. A host that polls that word therefore never sees a partly written frame. A frame that does not fit in the remaining space is dropped, and an overflow pulse is raised. A frame that ends with its error flag set can be discarded, and it then leaves no usable trace. Each committed frame raises a one-cycle receive interrupt.

Top module: `rxr_writer`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) puts the write position at byte address {lower page, 0x00}. It sets the stop address to {upper page, 0xFE}, so the whole ring (upper minus lower plus one pages) can be filled before any stop write. All output strobes are low during reset and in the cycle after it.
- R2: Frame byte i goes to data word i/2, in the low byte when i is even and in the high byte when i is odd. Data word 0 sits 8 bytes after the header start. A frame with an odd byte count has its last word padded with 0x00 in the high byte.
- R3: The header word at the header start is written last, after the three other header words, with the value 0x0008. When a frame of two or more bytes is accepted, that word is first written with 0x0000, in the cycle after its first byte.
- R4: The status word at header start + 2 is 0x2000 for a frame without error. For an errored frame that is kept (discard disabled) it is 0x0001. The value 0x0001 lies inside the error mask 0x0D81, and bit 13 is clear.
- R5: The word at header start + 4 holds the byte address of the next frame's header, which is the word that follows the last data word. The word at header start + 6 holds the byte count in bits 13:0, with bits 15:14 zero.
- R6: The word after byte address {upper page, 0xFE} is {lower page, 0x00}. Header and data words wrap there, and no write falls outside the two pages.
- R7: A frame whose header and data would need more words than remain between the write position and the stop address is dropped. A one-cycle overflow pulse is raised, no write lands on an unread committed word, and the next frame starts at the same position. A stop write restores the space up to the new stop address.
- R8: When discard is enabled, a frame whose last byte carries the error flag produces no header and no interrupt. The next frame is stored at the same header address.
- R9: rx_irq pulses for exactly one cycle per committed frame, in the same cycle as the 0x0008 event write.
- R10: A start byte that arrives while a header is being written is ignored. It produces no write, no interrupt and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_lo_page | input | 8 | First page of the receive ring (high byte of its byte address) |
| cfg_hi_page | input | 8 | Last page of the receive ring |
| cfg_discard_bad | input | 1 | Drop frames that end with the error flag |
| stop_we | input | 1 | Host write strobe for the stop address |
| stop_wdata | input | 16 | New stop byte address (last address that may be written) |
| in_valid | input | 1 | A byte is present on in_data |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_eof | input | 1 | This byte is the last byte of a frame |
| in_err | input | 1 | Frame error, qualified by in_eof |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Buffer RAM write strobe |
| mem_addr | output | 15 | Buffer RAM word address (byte address divided by two) |
| mem_wdata | output | 16 | Buffer RAM write data |
| rx_irq | output | 1 | One-cycle pulse per committed frame |
| rx_ovf | output | 1 | One-cycle pulse per frame dropped for lack of space |

## Verification
A wrong free-space count has two visible effects. A frame can be accepted and then land on a word already marked as unread, and this shows on mem_addr at the faulty write itself. Or the overflow pulse appears one frame too early or too late in a deterministic fill sequence. A stale write pointer or a misplaced wrap shows in the next frame's header address and next-frame pointer, one frame after the fault. A wrong header order or a wrong header value is seen on the RAM port within the four header cycles that follow the last byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int PAGE_W      = 8;
  localparam int ADDR_W      = PAGE_W + 8;
  localparam int WORD_W      = 16;
  localparam int CNT_W       = 14;
  localparam int HDR_WORDS   = 4;
  localparam int PAGE_WLOG2  = 7;

  typedef logic [ADDR_W-1:0] baddr_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t EVT_DONE = 16'h0008;
  localparam word_t STS_GOOD = 16'h2000;
  localparam word_t STS_BAD  = 16'h0001;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_DROP, S_H_CNT, S_H_NXT, S_H_STS, S_H_EVT
  } wr_state_t;

  // Byte address of the word after a, wrapping from the top word of hi to lo.
  function automatic baddr_t ring_step(baddr_t a, page_t lo, page_t hi);
    logic [ADDR_W-2:0] w;
    w = a[ADDR_W-1:1];
    if (w >= {hi, {PAGE_WLOG2{1'b1}}}) return {lo, 8'h00};
    w = w + 1'b1;
    return {w, 1'b0};
  endfunction

  // Number of 16-bit words in the ring.
  function automatic baddr_t ring_words(page_t lo, page_t hi);
    return (baddr_t'(hi) - baddr_t'(lo) + 1'b1) << PAGE_WLOG2;
  endfunction

  // Words usable from 'from' up to and including the stop word.
  function automatic baddr_t ring_space(baddr_t from, baddr_t stop, page_t lo, page_t hi);
    baddr_t base_w, pf, ps;
    base_w = baddr_t'({lo, {PAGE_WLOG2{1'b0}}});
    pf = baddr_t'(from[ADDR_W-1:1]) - base_w;
    ps = baddr_t'(stop[ADDR_W-1:1]) - base_w;
    if (ps >= pf) return ps - pf + 1'b1;
    return ps + ring_words(lo, hi) - pf + 1'b1;
  endfunction
endpackage

// File: rtl/rxr_hdr_addr.sv
module rxr_hdr_addr
  import rxr_pkg::*;
#(
  parameter int NWORDS = HDR_WORDS
) (
  input  baddr_t base,
  input  page_t  lo,
  input  page_t  hi,
  output baddr_t hdr_a [NWORDS],
  output baddr_t data_a
);
  baddr_t chain [NWORDS+1];

  assign chain[0] = base;
  for (genvar k = 1; k <= NWORDS; k++) begin : g_step
    assign chain[k] = ring_step(chain[k-1], lo, hi);
  end
  for (genvar k = 0; k < NWORDS; k++) begin : g_out
    assign hdr_a[k] = chain[k];
  end
  assign data_a = chain[NWORDS];
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic             last,
  input  logic [7:0]       din,
  output logic             emit,
  output word_t            word,
  output logic [CNT_W-1:0] nbytes
);
  logic             pend;
  logic [7:0]       low_b;
  logic [CNT_W-1:0] cnt;
  logic             pend_eff;
  logic [CNT_W-1:0] cnt_eff;

  always_comb begin
    pend_eff = start ? 1'b0 : pend;
    cnt_eff  = start ? '0 : cnt;
    emit     = take && (pend_eff || last);
    word     = pend_eff ? {din, low_b} : {8'h00, din};
    nbytes   = cnt_eff + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      low_b <= '0;
      cnt   <= '0;
    end else if (take) begin
      pend  <= !pend_eff && !last;
      low_b <= din;
      cnt   <= nbytes;
    end
  end
endmodule

// File: rtl/rxr_room.sv
module rxr_room
  import rxr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  page_t  lo,
  input  page_t  hi,
  input  logic   stop_we,
  input  baddr_t stop_wdata,
  input  logic   commit,
  input  baddr_t commit_words,
  input  baddr_t next_start,
  output baddr_t room
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      room <= ring_space({lo, 8'h00}, {hi, 8'hFE}, lo, hi);
    end else if (stop_we) begin
      room <= ring_space(next_start, stop_wdata, lo, hi);
    end else if (commit) begin
      room <= room - commit_words;
    end
  end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_lo_page,
  input  logic [7:0]  cfg_hi_page,
  input  logic        cfg_discard_bad,
  input  logic        stop_we,
  input  logic [15:0] stop_wdata,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_err,
  input  logic [7:0]  in_data,
  output logic        mem_we,
  output logic [14:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        rx_irq,
  output logic        rx_ovf
);
  wr_state_t        st;
  baddr_t           wp, hs, dp, dwords, nxt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  logic              wr_en_q, irq_q, ovf_q, cnt_wr_q;
  logic [ADDR_W-2:0] wr_addr_q;
  word_t             wr_data_q;

  // Named events used by the FSM and by the checker.
  logic             start, take, bad, fits;
  logic             ev_drop, ev_data_wr, ev_clear, ev_end_ok, ev_commit_begin, ev_discard;
  logic             pk_emit;
  word_t            pk_word;
  logic [CNT_W-1:0] pk_nbytes;
  baddr_t           dw_eff, base, d0, wr_addr_data, next_after, room;
  baddr_t           hdr_a [HDR_WORDS];

  assign start = (st == S_IDLE) && in_valid && in_sof;
  assign take  = start || ((st == S_DATA) && in_valid);
  assign bad   = in_err && cfg_discard_bad;

  rxr_packer u_pack (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take), .last(in_eof),
    .din(in_data), .emit(pk_emit), .word(pk_word), .nbytes(pk_nbytes)
  );

  assign base = start ? wp : hs;

  rxr_hdr_addr #(.NWORDS(HDR_WORDS)) u_hdr (
    .base(base), .lo(cfg_lo_page), .hi(cfg_hi_page), .hdr_a(hdr_a), .data_a(d0)
  );

  always_comb begin
    dw_eff          = start ? '0 : dwords;
    fits            = (dw_eff + baddr_t'(HDR_WORDS + 1)) <= room;
    wr_addr_data    = start ? d0 : dp;
    next_after      = ring_step(wr_addr_data, cfg_lo_page, cfg_hi_page);
    ev_drop         = start ? !fits : (take && pk_emit && !fits);
    ev_data_wr      = take && pk_emit && fits;
    ev_clear        = start && fits && !in_eof;
    ev_end_ok       = take && in_eof && fits;
    ev_commit_begin = ev_end_ok && !bad;
    ev_discard      = ev_end_ok && bad;
  end

  rxr_room u_room (
    .clk(clk), .rst_n(rst_n), .lo(cfg_lo_page), .hi(cfg_hi_page),
    .stop_we(stop_we), .stop_wdata(stop_wdata),
    .commit(st == S_H_EVT), .commit_words(dwords + baddr_t'(HDR_WORDS)),
    .next_start((st == S_H_EVT) ? nxt_q : wp), .room(room)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wp        <= {cfg_lo_page, 8'h00};
      hs        <= '0;
      dp        <= '0;
      dwords    <= '0;
      nxt_q     <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      irq_q     <= 1'b0;
      ovf_q     <= 1'b0;
      cnt_wr_q  <= 1'b0;
    end else begin
      wr_en_q  <= 1'b0;
      irq_q    <= 1'b0;
      ovf_q    <= ev_drop;
      cnt_wr_q <= 1'b0;
      if (ev_data_wr) begin
        wr_en_q   <= 1'b1;
        wr_addr_q <= wr_addr_data[ADDR_W-1:1];
        wr_data_q <= pk_word;
        dp        <= next_after;
        dwords    <= dw_eff + 1'b1;
      end
      if (ev_clear) begin
        wr_en_q   <= 1'b1;
        wr_addr_q <= hdr_a[0][ADDR_W-1:1];
        wr_data_q <= '0;
      end
      unique case (st)
        S_IDLE: if (start) begin
          if (!fits) begin
            st <= in_eof ? S_IDLE : S_DROP;
          end else begin
            hs <= wp;
            if (!in_eof) begin
              dp     <= d0;
              dwords <= '0;
              st     <= S_DATA;
            end
          end
        end
        S_DATA: if (ev_drop) st <= in_eof ? S_IDLE : S_DROP;
        S_DROP: if (in_valid && in_eof) st <= S_IDLE;
        S_H_CNT: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= hdr_a[3][ADDR_W-1:1];
          wr_data_q <= word_t'(cnt_q);
          cnt_wr_q  <= 1'b1;
          st        <= S_H_NXT;
        end
        S_H_NXT: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= hdr_a[2][ADDR_W-1:1];
          wr_data_q <= nxt_q;
          st        <= S_H_STS;
        end
        S_H_STS: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= hdr_a[1][ADDR_W-1:1];
          wr_data_q <= err_q ? STS_BAD : STS_GOOD;
          st        <= S_H_EVT;
        end
        S_H_EVT: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= hdr_a[0][ADDR_W-1:1];
          wr_data_q <= EVT_DONE;
          irq_q     <= 1'b1;
          wp        <= nxt_q;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (ev_commit_begin) begin
        nxt_q <= next_after;
        cnt_q <= pk_nbytes;
        err_q <= in_err;
        st    <= S_H_CNT;
      end
      if (ev_discard) st <= S_IDLE;
    end
  end

  assign mem_we    = wr_en_q;
  assign mem_addr  = wr_addr_q;
  assign mem_wdata = wr_data_q;
  assign rx_irq    = irq_q;
  assign rx_ovf    = ovf_q;
endmodule

// File: rtl/rxr_check.sv
module rxr_check
  import rxr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input page_t             lo,
  input page_t             hi,
  input logic              mem_we,
  input logic [ADDR_W-2:0] mem_addr,
  input word_t             mem_wdata,
  input logic              rx_irq,
  input logic              rx_ovf,
  input logic              cnt_wr,
  input baddr_t            room
);
  baddr_t evt_next;
  baddr_t ring_n;
  assign evt_next = ring_step({mem_addr, 1'b0}, lo, hi);
  assign ring_n   = ring_words(lo, hi);

  AST_IRQ_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (mem_we && mem_wdata == EVT_DONE)); // R9
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R9
  AST_EVT_AFTER_STS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ($past(mem_we) && $past(mem_addr) == evt_next[ADDR_W-1:1])); // R3
  AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> !mem_we); // R7
  AST_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {lo, {PAGE_WLOG2{1'b0}}} && mem_addr <= {hi, {PAGE_WLOG2{1'b1}}})); // R6
  AST_CNT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> (mem_we && mem_wdata[15:14] == 2'b00)); // R5
  AST_ROOM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    room <= ring_n); // R7
  AST_IRQ_OVF_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq && rx_ovf)); // R10
endmodule

bind rxr_writer rxr_check u_chk (
  .clk(clk), .rst_n(rst_n), .lo(cfg_lo_page), .hi(cfg_hi_page),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rx_irq(rx_irq), .rx_ovf(rx_ovf), .cnt_wr(cnt_wr_q), .room(room)
);

// File: tb/sim_rxr_writer.sv
`timescale 1ns/1ps
module sim_rxr_writer;
  localparam logic [7:0]  LO  = 8'h10;
  localparam logic [7:0]  HI  = 8'h11;
  localparam int          NW  = 256;
  localparam logic [15:0] LOB = 16'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disc = 1'b1;
  logic stop_we = 1'b0;
  logic [15:0] stop_wdata = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic mem_we, rx_irq, rx_ovf;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;

  int nchk = 0, nfail = 0, irq_n = 0, ovf_n = 0, used = 0;
  logic [15:0] b_wp = LOB;
  logic [15:0] shadow [0:32767];
  bit          busy   [0:32767];

  always #4 clk = ~clk;

  rxr_writer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lo_page(LO), .cfg_hi_page(HI),
    .cfg_discard_bad(disc), .stop_we(stop_we), .stop_wdata(stop_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rx_irq(rx_irq), .rx_ovf(rx_ovf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (busy[mem_addr]) check(1'b0, "R7 write onto unread word", int'(mem_addr), -1);
      shadow[mem_addr] = mem_wdata;
    end
    if (rx_irq) irq_n++;
    if (rx_ovf) ovf_n++;
  end

  function automatic logic [15:0] bnext(logic [15:0] a);
    int off;
    off = (int'(a) - int'(LOB) + 2) % (NW * 2);
    return 16'(int'(LOB) + off);
  endfunction

  function automatic logic [15:0] bprev(logic [15:0] a);
    int off;
    off = (int'(a) - int'(LOB) - 2 + NW * 2) % (NW * 2);
    return 16'(int'(LOB) + off);
  endfunction

  function automatic logic [7:0] bbyte(int seed, int i);
    return 8'((seed * 29 + i * 11 + 3) & 255);
  endfunction

  task automatic host_free();
    stop_wdata = bprev(b_wp) + 16'd1;
    stop_we = 1'b1;
    @(negedge clk);
    stop_we = 1'b0;
    for (int k = 0; k < 32768; k++) busy[k] = 1'b0;
    used = 0;
    @(negedge clk);
  endtask

  task automatic send_frame(input int len, input bit err, input int seed, input bit b2b);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_err = err && (i == len - 1);
      in_data = bbyte(seed, i);
      @(negedge clk);
    end
    if (b2b) begin
      in_sof = 1'b1; in_eof = 1'b1; in_err = 1'b0; in_data = 8'h55;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_frame(input int len, input bit err, input int seed, input bit b2b);
    int need, irq0, ovf0;
    logic [15:0] hs, a, nxt;
    logic [15:0] exp;
    logic [7:0] hb;
    string tag;
    need = 4 + (len + 1) / 2;
    hs = b_wp; irq0 = irq_n; ovf0 = ovf_n;
    send_frame(len, err, seed, b2b);
    if (used + need > NW) begin
      check(ovf_n == ovf0 + 1, "R7 overflow pulse count", ovf_n - ovf0, 1);
      check(irq_n == irq0, "R7 dropped frame raised irq", irq_n - irq0, 0);
    end else if (err && disc) begin
      check(irq_n == irq0, "R8 discarded frame raised irq", irq_n - irq0, 0);
      check(ovf_n == ovf0, "R8 discarded frame raised ovf", ovf_n - ovf0, 0);
      if (len >= 2) check(shadow[hs >> 1] == 16'h0000, "R3 event word not cleared", shadow[hs >> 1], 0);
    end else begin
      nxt = hs;
      for (int k = 0; k < need; k++) nxt = bnext(nxt);
      a = hs;
      for (int k = 0; k < need; k++) begin
        if (k == 0) begin exp = 16'h0008; tag = "R3 event word"; end
        else if (k == 1) begin exp = err ? 16'h0001 : 16'h2000; tag = "R4 status word"; end
        else if (k == 2) begin exp = nxt; tag = "R5 next pointer"; end
        else if (k == 3) begin exp = 16'(len); tag = "R5 byte count"; end
        else begin
          hb = (2 * (k - 4) + 1 < len) ? bbyte(seed, 2 * (k - 4) + 1) : 8'h00;
          exp = {hb, bbyte(seed, 2 * (k - 4))};
          tag = (a < hs) ? "R6 wrapped data word" : "R2 data word";
        end
        check(shadow[a >> 1] == exp, tag, shadow[a >> 1], exp);
        busy[a >> 1] = 1'b1;
        a = bnext(a);
      end
      check(irq_n == irq0 + 1, "R9 irq pulses per commit", irq_n - irq0, 1);
      check(ovf_n == ovf0, "R10 stray overflow", ovf_n - ovf0, 0);
      used += need;
      b_wp = nxt;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32768; k++) begin shadow[k] = 16'hFFFF; busy[k] = 1'b0; end
    repeat (3) @(negedge clk);
    check(mem_we == 1'b0 && rx_irq == 1'b0 && rx_ovf == 1'b0, "R1 outputs in reset",
          {mem_we, rx_irq, rx_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_we == 1'b0 && rx_irq == 1'b0 && rx_ovf == 1'b0, "R1 outputs after reset",
          {mem_we, rx_irq, rx_ovf}, 0);

    // R1 R7: fill the ring under the reset stop address
    for (int f = 0; f < 14; f++) run_frame(30, 1'b0, f, 1'b0);
    run_frame(10, 1'b0, 50, 1'b0);   // exactly fills the last 9 words
    run_frame(1, 1'b0, 51, 1'b0);    // no room at start
    run_frame(2, 1'b0, 52, 1'b0);
    host_free();

    // R2 R5 R6 R9: length sweep with wraps
    for (int len = 1; len <= 48; len++) begin
      run_frame(len, 1'b0, 100 + len, 1'b0);
      host_free();
    end

    // R8: discarded error frames, then a good frame at the same place
    for (int len = 1; len <= 6; len++) run_frame(len, 1'b1, 200 + len, 1'b0);
    run_frame(7, 1'b0, 210, 1'b0);
    host_free();

    // R4: error frame kept when discard is off
    disc = 1'b0;
    run_frame(5, 1'b1, 220, 1'b0);
    disc = 1'b1;
    host_free();

    // R10: start byte during header writes is ignored
    run_frame(4, 1'b0, 230, 1'b1);
    run_frame(9, 1'b0, 231, 1'b0);
    host_free();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule